// File: doc/BRIEF.md
# Bit-Serial Loaded Parallel Printer Port

This block connects an 8-bit CPU bus to a parallel printer that uses the Centronics convention: eight data lines, an active-low strobe and a busy input. The data lines are not loaded by one parallel write. Software sends a character one bit per write, with the most significant bit first. Each write to the data select moves bit 7 of the CPU write data into an 8-bit shift register, and the register's parallel outputs drive the printer data lines directly.

After eight such writes, software fires the strobe by reading the strobe select. A write to that select does nothing. The strobe pulse lasts a fixed number of clock cycles, set by a parameter. Software polls the printer's busy line by reading the status select, where it appears on bit 5.

An external address decoder supplies one-cycle read and write enables and a 2-bit select code. Read data is registered, so it is valid in the cycle after the read enable.

Top module: `prn_serial_port`

## Requirements
- R1: While reset is asserted, and after it is released, `prn_data` is 8'h00, `prn_strobe_n` is 1 and `cpu_rdata` is 8'hFF.
- R2: A write with `reg_sel` = 2'b00 (data) shifts `prn_data` up by one place and loads `cpu_wdata[7]` into `prn_data[0]`. After eight writes, the first bit written is on `prn_data[7]`.
- R3: Writes with any other select, every read, and `cpu_wdata[6:0]` leave `prn_data` unchanged.
- R4: A read with `reg_sel` = 2'b10 (strobe) drives `prn_strobe_n` low from the clock edge that samples the read. It stays low for exactly STROBE_CYCLES cycles (default 4), then returns high.
- R5: A write with `reg_sel` = 2'b10 does not pull `prn_strobe_n` low.
- R6: A strobe read that arrives while a pulse is active restarts the pulse. The strobe then stays low for STROBE_CYCLES cycles counted from that later read.
- R7: A read with `reg_sel` = 2'b01 (status) returns the busy input on `cpu_rdata[5]` (1 = busy, 0 = ready) after a two-flop synchronizer. The read data is registered. As a result, a status read issued in the same cycle as a busy change, or in the next cycle, returns the old value, and a read issued two cycles later returns the new value.
- R8: Every read returns 1 on all bits other than bit 5. Reads with select 2'b00, 2'b10 or 2'b11 return 8'hFF.
- R9: `cpu_rdata` changes only on a read and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_en | input | 1 | One-cycle read enable from the address decoder |
| wr_en | input | 1 | One-cycle write enable from the address decoder |
| reg_sel | input | 2 | 00 data, 01 status, 10 strobe, 11 unused |
| cpu_wdata | input | 8 | CPU write data; only bit 7 is used |
| cpu_rdata | output | 8 | Registered read data |
| prn_data | output | 8 | Printer data lines |
| prn_strobe_n | output | 1 | Active-low printer strobe |
| prn_busy | input | 1 | Printer busy input, asynchronous |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle, because the decoder serves a single bus master. The bench issues every access as one enable for one cycle, with one access per cycle.

The R7 latency checks rely on `prn_busy` changing only between clock edges and then staying stable. The bench changes it only on the falling clock edge. It then issues back-to-back status reads to find the exact cycle where the new value first appears.

// File: rtl/prn_pkg.sv
package prn_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'b00,
    SEL_STATUS = 2'b01,
    SEL_STROBE = 2'b10,
    SEL_SPARE  = 2'b11
  } prn_sel_e;

endpackage

// File: rtl/prn_busy_sync.sv
module prn_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // Next state: each stage takes the one before it.
  always_comb begin
    stage_d[0] = busy_async;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign busy_sync = stage_q[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      AST_SYNC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[g] == $past(stage_q[g-1])); // R7
    end
  endgenerate

endmodule

// File: rtl/prn_shift_reg.sv
module prn_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             serial_in,
  output logic [WIDTH-1:0] par_out
);

  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;

  // Next state: first bit in travels towards the MSB.
  always_comb begin
    if (shift_en) begin
      sr_d = {sr_q[WIDTH-2:0], serial_in};
    end else begin
      sr_d = sr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign par_out = sr_q;

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(serial_in)})); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(par_out)); // R3

endmodule

// File: rtl/prn_strobe_gen.sv
module prn_strobe_gen #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic strobe_n
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIDTH);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             strobe_n_q;
  logic             strobe_n_d;

  // Next state: a fire reloads the count, so a pulse in progress restarts.
  always_comb begin
    if (fire) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    strobe_n_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      strobe_n_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      strobe_n_q <= strobe_n_d;
    end
  end

  assign strobe_n = strobe_n_q;

  AST_STROBE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !strobe_n); // R4
  AST_STROBE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q == CNT_W'(1)) |=> strobe_n); // R4
  AST_STROBE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == LOAD)); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R6

endmodule

// File: rtl/prn_serial_port.sv
module prn_serial_port #(
  parameter int SR_WIDTH      = 8,
  parameter int STROBE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int BUSY_BIT      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic                       wr_en,
  input  logic [1:0]                 reg_sel,
  input  logic [prn_pkg::BUS_W-1:0]  cpu_wdata,
  output logic [prn_pkg::BUS_W-1:0]  cpu_rdata,
  output logic [SR_WIDTH-1:0]        prn_data,
  output logic                       prn_strobe_n,
  input  logic                       prn_busy
);

  import prn_pkg::*;

  localparam logic [BUS_W-1:0] RD_FILL = '1;

  logic             shift_en;
  logic             strobe_fire;
  logic             status_rd;
  logic             busy_sync;
  logic [BUS_W-1:0] rdata_q;
  logic [BUS_W-1:0] rdata_d;
  logic             unused_wbits;

  assign unused_wbits = ^cpu_wdata[BUS_W-2:0];

  // Select decode
  assign shift_en    = wr_en && (reg_sel == SEL_DATA);
  assign strobe_fire = rd_en && (reg_sel == SEL_STROBE);
  assign status_rd   = rd_en && (reg_sel == SEL_STATUS);

  prn_shift_reg #(.WIDTH(SR_WIDTH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .serial_in (cpu_wdata[BUS_W-1]),
    .par_out   (prn_data)
  );

  prn_strobe_gen #(.WIDTH(STROBE_CYCLES)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (strobe_fire),
    .strobe_n (prn_strobe_n)
  );

  prn_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_async (prn_busy),
    .busy_sync  (busy_sync)
  );

  // Read data next state
  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = RD_FILL;
      if (status_rd) begin
        rdata_d[BUSY_BIT] = busy_sync;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= RD_FILL;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign cpu_rdata = rdata_q;

  AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (cpu_rdata[BUSY_BIT] == $past(busy_sync))); // R7
  AST_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !status_rd) |=> (cpu_rdata == RD_FILL)); // R8
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(cpu_rdata)); // R9
  AST_NO_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && prn_strobe_n) |=> prn_strobe_n); // R5
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R3

endmodule

// File: tb/prn_serial_port_test.sv
module prn_serial_port_test;

  localparam int W = 4;

  logic       clk;
  logic       rst_n;
  logic       rd_en;
  logic       wr_en;
  logic [1:0] reg_sel;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic [7:0] prn_data;
  logic       prn_strobe_n;
  logic       prn_busy;

  int checks;
  int errors;

  prn_serial_port #(.STROBE_CYCLES(W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .reg_sel      (reg_sel),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .prn_data     (prn_data),
    .prn_strobe_n (prn_strobe_n),
    .prn_busy     (prn_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Starts and ends on a falling edge; one enable for one cycle.
  task automatic access(input bit rd, input bit wr, input logic [1:0] sel, input logic [7:0] d);
    rd_en = rd; wr_en = wr; reg_sel = sel; cpu_wdata = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; cpu_wdata = 8'h00;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      access(1'b0, 1'b1, 2'b00, {b[k], 7'(b * 37 + k)});
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!prn_strobe_n && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    checks = 0; errors = 0;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; reg_sel = 2'b00;
    cpu_wdata = 8'h00; prn_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(prn_data == 8'h00, "R1 data in reset", prn_data, 0);
    check(prn_strobe_n == 1'b1, "R1 strobe in reset", prn_strobe_n, 1);
    check(cpu_rdata == 8'hFF, "R1 rdata in reset", cpu_rdata, 8'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(prn_data == 8'h00, "R1 data after reset", prn_data, 0);
    check(prn_strobe_n == 1'b1, "R1 strobe after reset", prn_strobe_n, 1);

    // R2: every byte value, MSB first, with junk in the low write bits
    for (int b = 0; b < 256; b++) begin
      send_byte(8'(b));
      check(prn_data == 8'(b), "R2 byte sweep", prn_data, b);
    end
    // R2: partial shift, 3 ones after 0x00 land in bits 2:0
    send_byte(8'h00);
    for (int k = 0; k < 3; k++) access(1'b0, 1'b1, 2'b00, 8'h80);
    check(prn_data == 8'h07, "R2 partial shift", prn_data, 8'h07);

    // R3: other selects and reads do not touch the data lines
    send_byte(8'hA5);
    for (int s = 1; s < 4; s++) begin
      access(1'b0, 1'b1, 2'(s), 8'hFF);
      check(prn_data == 8'hA5, "R3 write other select", prn_data, 8'hA5);
      access(1'b0, 1'b1, 2'(s), 8'h00);
      check(prn_data == 8'hA5, "R3 write other select", prn_data, 8'hA5);
    end
    for (int s = 0; s < 4; s++) begin
      access(1'b1, 1'b0, 2'(s), 8'hFF);
      check(prn_data == 8'hA5, "R3 read", prn_data, 8'hA5);
    end
    repeat (W + 2) @(negedge clk);

    // R4: pulse width
    check(prn_strobe_n == 1'b1, "R4 idle strobe", prn_strobe_n, 1);
    access(1'b1, 1'b0, 2'b10, 8'h00);
    count_low(n);
    check(n == W, "R4 strobe width", n, W);

    // R5: a write to the strobe select gives no pulse
    access(1'b0, 1'b1, 2'b10, 8'hFF);
    n = 0;
    for (int k = 0; k < W + 2; k++) begin
      if (!prn_strobe_n) n++;
      @(negedge clk);
    end
    check(n == 0, "R5 write no strobe", n, 0);

    // R6: restart during a pulse
    access(1'b1, 1'b0, 2'b10, 8'h00);
    repeat (2) @(negedge clk);
    check(prn_strobe_n == 1'b0, "R6 mid pulse", prn_strobe_n, 0);
    access(1'b1, 1'b0, 2'b10, 8'h00);
    count_low(n);
    check(n == W, "R6 restarted width", n, W);

    // R7 and R8: busy latency, both directions
    for (int v = 0; v < 2; v++) begin
      logic nv;
      nv = ~prn_busy;
      prn_busy = nv;
      access(1'b1, 1'b0, 2'b01, 8'h00);
      check(cpu_rdata[5] == ~nv, "R7 same cycle old", cpu_rdata[5], ~nv);
      access(1'b1, 1'b0, 2'b01, 8'h00);
      check(cpu_rdata[5] == ~nv, "R7 next cycle old", cpu_rdata[5], ~nv);
      access(1'b1, 1'b0, 2'b01, 8'h00);
      check(cpu_rdata[5] == nv, "R7 two cycles new", cpu_rdata[5], nv);
      check(cpu_rdata == (nv ? 8'hFF : 8'hDF), "R8 status fill", cpu_rdata,
            nv ? 8'hFF : 8'hDF);
    end
    prn_busy = 1'b0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      if (s != 1) begin
        access(1'b1, 1'b0, 2'(s), 8'h00);
        check(cpu_rdata == 8'hFF, "R8 non-status read", cpu_rdata, 8'hFF);
      end
    end
    repeat (W + 2) @(negedge clk);

    // R9: read data holds without reads
    access(1'b1, 1'b0, 2'b01, 8'h00);
    check(cpu_rdata == 8'hDF, "R9 status ready", cpu_rdata, 8'hDF);
    prn_busy = 1'b1;
    repeat (5) @(negedge clk);
    access(1'b0, 1'b1, 2'b00, 8'hFF);
    access(1'b0, 1'b1, 2'b01, 8'hFF);
    check(cpu_rdata == 8'hDF, "R9 hold", cpu_rdata, 8'hDF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule